// File: doc/BRIEF.md
# Per-Bank Row Cache Controller

This block models the control and data path of a DRAM whose banks each carry a single SRAM line as wide as one row. The line sits beside the sense amplifiers, not in them. A request names a bank, a row and a column. A read whose row matches the bank's tag is answered from the line after one cycle. A read that misses waits for the core-array latency, copies the whole row into the line, updates the tag and then returns the word. Refresh and precharge keep the array busy for a while. They never touch the line, so hits keep flowing while the array is busy.

Writes always reach the array. In the normal write mode, a write to the cached row also updates the line, so the line and the array stay equal. In the no-transfer mode, the write goes only through the sense amplifiers to the array. If it targets the cached row, that line is marked stale and the next read of it reloads the row from the array. The block serves one request at a time, so read data returns in request order.

Top module: `rowcache_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and rd_valid is 0.
- R2: A read whose row matches the valid tag of its bank returns the line word with rd_hit=1 and rd_valid high in the cycle after the accepting clock edge.
- R3: A read that misses returns the array word with rd_hit=0 and rd_valid high CORE_LAT cycles later than a hit would. It loads the whole row, so a later read of any column of that row hits.
- R4: Each bank holds exactly one direct-mapped line. A miss to another row of the same bank replaces the line. Lines of other banks are unaffected.
- R5: A write with req_nwt=0 always updates the array. If it hits, it also updates the line, and a following hit read returns the new word.
- R6: A write with req_nwt=1 updates only the array. If it targets the cached row, the next read of that row misses and returns the new array word. If it targets another row, the cached row still hits.
- R7: A pulse on ref_req holds array accesses for REF_CYC cycles. A miss accepted on the same edge as the pulse returns 1+REF_CYC+CORE_LAT cycles after acceptance. Hits are not delayed.
- R8: Refresh and precharge never invalidate or alter a cached line. A read of the cached row after either still hits with the stored word.
- R9: A pulse on pch_req holds array accesses for PRE_CYC cycles. A miss accepted on the same edge returns 1+PRE_CYC+CORE_LAT cycles after acceptance. Hits are not delayed.
- R10: Only one request is outstanding. req_ready is 0 from the edge that accepts a miss or a write until that access completes, and rd_valid is a one-cycle pulse.
- R11: At reset, array word (bank b, row r, column c) holds (37*b + 11*r + 3*c + 1) mod 2^DW, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nwt | input | 1 | Write bypasses the line (no-transfer mode) |
| req_bank | input | $clog2(NBANK) | Bank index |
| req_row | input | $clog2(NROW) | Row index |
| req_col | input | $clog2(NCOL) | Column index |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_hit | output | 1 | Returned read was a line hit |
| rd_data | output | DW | Read data |
| ref_req | input | 1 | Refresh pulse, array busy REF_CYC cycles |
| pch_req | input | 1 | Precharge pulse, array busy PRE_CYC cycles |

## Verification
A hit answers one cycle after its accepting edge. A miss answers after 1+CORE_LAT cycles, and after another REF_CYC or PRE_CYC cycles when a refresh or precharge pulse lands on the same edge. Inputs change on falling edges. The bench counts falling edges from acceptance until rd_valid rises and compares that count, the hit flag and the word against values computed from the requirements. Writes are checked indirectly. The bench waits for req_ready to return, then follows each write with reads whose hit or miss outcome and latency show whether the line was kept, refreshed or marked stale.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_ARRAY} rc_state_e;

    function automatic logic [31:0] rc_seed_word(input int b, input int r, input int c);
        return 32'(37 * b + 11 * r + 3 * c + 1);
    endfunction
endpackage

// File: rtl/rc_busy_timer.sv
module rc_busy_timer #(
    parameter int REF_CYC = 5,
    parameter int PRE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_req,
    input  logic pch_req,
    output logic busy
);
    localparam int MAXC = (REF_CYC > PRE_CYC) ? REF_CYC : PRE_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ref_req && cnt_q < TW'(REF_CYC))
            cnt_d = TW'(REF_CYC);
        else if (pch_req && cnt_q < TW'(PRE_CYC))
            cnt_d = TW'(PRE_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/rc_tag_match.sv
module rc_tag_match #(
    parameter int NBANK = 4,
    parameter int RW    = 3,
    parameter int BW    = 2
) (
    input  logic [NBANK-1:0][RW-1:0] tag,
    input  logic [NBANK-1:0]         vld,
    input  logic [BW-1:0]            bank,
    input  logic [RW-1:0]            row,
    output logic                     hit
);
    logic [NBANK-1:0] match;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign match[g] = vld[g] && (tag[g] == row);
    end

    assign hit = match[bank];
endmodule

// File: rtl/rowcache_ctrl.sv
module rowcache_ctrl #(
    parameter int NBANK    = 4,
    parameter int NROW     = 8,
    parameter int NCOL     = 4,
    parameter int DW       = 8,
    parameter int CORE_LAT = 3,
    parameter int REF_CYC  = 5,
    parameter int PRE_CYC  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_nwt,
    input  logic [$clog2(NBANK)-1:0] req_bank,
    input  logic [$clog2(NROW)-1:0]  req_row,
    input  logic [$clog2(NCOL)-1:0]  req_col,
    input  logic [DW-1:0]            req_wdata,
    output logic                     rd_valid,
    output logic                     rd_hit,
    output logic [DW-1:0]            rd_data,
    input  logic                     ref_req,
    input  logic                     pch_req
);
    import rc_pkg::*;

    localparam int BW  = $clog2(NBANK);
    localparam int RW  = $clog2(NROW);
    localparam int CLW = $clog2(NCOL);
    localparam int CW  = $clog2(CORE_LAT + 1);

    typedef logic [NCOL-1:0][DW-1:0] row_t;

    typedef struct packed {
        rc_state_e                    st;
        logic [CW-1:0]                cnt;
        logic                         wr;
        logic [BW-1:0]                bank;
        logic [RW-1:0]                row;
        logic [CLW-1:0]               col;
        logic [DW-1:0]                wdata;
        logic [NBANK-1:0]             vld;
        logic [NBANK-1:0][RW-1:0]     tag;
        logic [NBANK-1:0]             [NCOL-1:0][DW-1:0] line;
        logic [NBANK-1:0][NROW-1:0]   [NCOL-1:0][DW-1:0] arr;
        logic                         rv;
        logic                         rh;
        logic [DW-1:0]                rd;
    } state_t;

    state_t s_d, s_q;
    logic   hit;
    logic   arr_busy;

    rc_tag_match #(.NBANK(NBANK), .RW(RW), .BW(BW)) u_match (
        .tag  (s_q.tag),
        .vld  (s_q.vld),
        .bank (req_bank),
        .row  (req_row),
        .hit  (hit)
    );

    rc_busy_timer #(.REF_CYC(REF_CYC), .PRE_CYC(PRE_CYC)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_req (ref_req),
        .pch_req (pch_req),
        .busy    (arr_busy)
    );

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        s.st = ST_IDLE;
        for (int b = 0; b < NBANK; b++)
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCOL; c++)
                    s.arr[b][r][c] = DW'(rc_seed_word(b, r, c));
        return s;
    endfunction

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        s_d.rh = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.wr    = req_write;
                    s_d.bank  = req_bank;
                    s_d.row   = req_row;
                    s_d.col   = req_col;
                    s_d.wdata = req_wdata;
                    s_d.cnt   = '0;
                    if (!req_write && hit) begin
                        s_d.rv = 1'b1;
                        s_d.rh = 1'b1;
                        s_d.rd = s_q.line[req_bank][req_col];
                    end else begin
                        s_d.st = ST_ARRAY;
                        if (req_write && hit) begin
                            if (req_nwt) s_d.vld[req_bank] = 1'b0;
                            else         s_d.line[req_bank][req_col] = req_wdata;
                        end
                    end
                end
            end
            ST_ARRAY: begin
                if (!arr_busy) begin
                    if (s_q.cnt == CW'(CORE_LAT - 1)) begin
                        s_d.st = ST_IDLE;
                        if (s_q.wr) begin
                            s_d.arr[s_q.bank][s_q.row][s_q.col] = s_q.wdata;
                        end else begin
                            s_d.line[s_q.bank] = s_q.arr[s_q.bank][s_q.row];
                            s_d.tag[s_q.bank]  = s_q.row;
                            s_d.vld[s_q.bank]  = 1'b1;
                            s_d.rv             = 1'b1;
                            s_d.rd             = s_q.arr[s_q.bank][s_q.row][s_q.col];
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign rd_valid  = s_q.rv;
    assign rd_hit    = s_q.rh;
    assign rd_data   = s_q.rd;
endmodule

// File: rtl/rc_ctrl_chk.sv
module rc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_hit,
    input logic ref_req
);
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rd_valid || !req_ready));

    // R2
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_valid);

    // R3
    miss_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit) |-> $past(!req_ready));

    // R7
    refresh_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> ##1 !(rd_valid && !rd_hit));
endmodule

bind rowcache_ctrl rc_ctrl_chk u_chk (.*);

// File: tb/rowcache_ctrl_test.sv
`timescale 1ns/1ps
module rowcache_ctrl_test;
    localparam int NBANK = 4, NROW = 8, NCOL = 4, DW = 8;
    localparam int CORE_LAT = 3, REF_CYC = 5, PRE_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_nwt = 0, ref_req = 0, pch_req = 0;
    logic [1:0] req_bank = 0;
    logic [2:0] req_row = 0;
    logic [1:0] req_col = 0;
    logic [DW-1:0] req_wdata = 0;
    logic req_ready, rd_valid, rd_hit;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_err = 0;
    logic [DW-1:0] mem [NBANK][NROW][NCOL];

    always #4 clk = ~clk;

    rowcache_ctrl #(.NBANK(NBANK), .NROW(NROW), .NCOL(NCOL), .DW(DW),
        .CORE_LAT(CORE_LAT), .REF_CYC(REF_CYC), .PRE_CYC(PRE_CYC)) uut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input string req, input int b, input int r, input int c,
                           input int ehit, input int elat, input bit rf, input bit pc);
        int lat;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_nwt = 0;
        req_bank = 2'(b); req_row = 3'(r); req_col = 2'(c);
        ref_req = rf; pch_req = pc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; ref_req = 0; pch_req = 0;
        if (ehit == 0) check({req, " R10 ready low during miss"}, int'(req_ready), 0);
        lat = 1;
        while (!rd_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check({req, " latency"}, lat, elat);
        check({req, " hit flag"}, int'(rd_hit), ehit);
        check({req, " data"}, int'(rd_data), int'(mem[b][r][c]));
    endtask

    task automatic do_write(input int b, input int r, input int c, input int d, input bit nwt);
        int w;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_nwt = nwt;
        req_bank = 2'(b); req_row = 3'(r); req_col = 2'(c); req_wdata = DW'(d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0; req_nwt = 0;
        check("R10 ready low during write", int'(req_ready), 0);
        w = 0;
        while (!req_ready && w < 40) begin
            @(negedge clk);
            w++;
        end
        mem[b][r][c] = DW'(d);
    endtask

    localparam int HIT = 1;
    localparam int MISS = 1 + CORE_LAT;

    task automatic t_reset();
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
    endtask

    task automatic t_miss_then_hit();
        do_read("R3 R11 first read miss", 0, 1, 2, 0, MISS, 0, 0);
        do_read("R3 R2 other column hits", 0, 1, 3, 1, HIT, 0, 0);
        do_read("R2 same word hits", 0, 1, 2, 1, HIT, 0, 0);
    endtask

    task automatic t_per_bank();
        do_read("R4 other bank misses", 1, 1, 0, 0, MISS, 0, 0);
        do_read("R4 bank0 line kept", 0, 1, 0, 1, HIT, 0, 0);
        do_read("R4 new row same bank misses", 0, 2, 0, 0, MISS, 0, 0);
        do_read("R4 old row replaced", 0, 1, 0, 0, MISS, 0, 0);
        do_read("R4 bank1 still cached", 1, 1, 3, 1, HIT, 0, 0);
    endtask

    task automatic t_normal_write();
        do_write(0, 1, 0, 8'hA5, 0);
        do_read("R5 write hit updates line", 0, 1, 0, 1, HIT, 0, 0);
        do_write(2, 6, 1, 8'h5A, 0);
        do_read("R5 write miss reaches array", 2, 6, 1, 0, MISS, 0, 0);
        do_read("R5 evict row", 0, 2, 0, 0, MISS, 0, 0);
        do_read("R5 array kept written word", 0, 1, 0, 0, MISS, 0, 0);
    endtask

    task automatic t_nwt_write();
        do_write(0, 1, 1, 8'h3C, 1);
        do_read("R6 cached row marked stale", 0, 1, 1, 0, MISS, 0, 0);
        do_write(0, 5, 0, 8'h77, 1);
        do_read("R6 other row write leaves line", 0, 1, 2, 1, HIT, 0, 0);
        do_read("R6 array holds bypass word", 0, 5, 0, 0, MISS, 0, 0);
    endtask

    task automatic t_refresh();
        do_read("R7 R8 hit during refresh", 0, 5, 0, 1, HIT, 1, 0);
        do_read("R8 hit after refresh", 0, 5, 3, 1, HIT, 0, 0);
        do_read("R7 miss stalled by refresh", 3, 7, 3, 0, MISS + REF_CYC, 1, 0);
    endtask

    task automatic t_precharge();
        do_read("R9 R8 hit during precharge", 3, 7, 0, 1, HIT, 0, 1);
        do_read("R9 miss stalled by precharge", 3, 4, 2, 0, MISS + PRE_CYC, 0, 1);
        do_read("R8 hit after precharge", 3, 4, 1, 1, HIT, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int b = 0; b < NBANK; b++)
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCOL; c++)
                    mem[b][r][c] = DW'(37 * b + 11 * r + 3 * c + 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_then_hit();
        t_per_bank();
        t_normal_write();
        t_nwt_write();
        t_refresh();
        t_precharge();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule